// File: doc/BRIEF.md
# Threshold-Release Transmit Byte FIFO

This block is a byte-wide frame buffer between a DMA engine that fills it and a line transmitter that drains it. Bytes arrive with a last-byte marker. The head frame becomes visible to the reader in two cases. The first is that more of its bytes are stored than a programmable threshold. The second is that the whole frame, up to and including its last byte, is already stored. A store-and-forward input turns the threshold path off, so that only complete frames go out.

The threshold is set by a 3-bit code. The code is not linear: it gives four large steps and four small ones. It is captured when the first byte of each frame is written.

A flush request empties the buffer. The flush flag is set by a one-cycle pulse and cannot be cleared from outside. The block clears it once its pointers and counters have returned to zero. Bytes the transmitter has already taken are not recalled, so a frame cut by a flush arrives at the line truncated.

Top module: `tx_thresh_fifo`

## Requirements
- R1: The threshold code `thr_code_i` selects a byte threshold: 0→64, 1→128, 2→192, 3→256, 4→40, 5→32, 6→24, 7→16.
- R2: With `store_fwd_i` low, an incomplete head frame raises `rd_valid_o` in the cycle after its stored byte count first becomes strictly greater than the threshold. At a count equal to the threshold, `rd_valid_o` stays low.
- R3: A frame shorter than the threshold raises `rd_valid_o` in the cycle after its last byte (`wr_last_i`=1) is written.
- R4: With `store_fwd_i` high, a frame that is not already being read is offered only while at least one complete frame is stored, whatever its length.
- R5: The threshold that applies to a frame is the code present when the frame's first byte is written. Later changes to `thr_code_i` do not affect that frame.
- R6: Once reading of a frame has begun, `rd_valid_o` stays high whenever bytes are stored, even if the count falls below the threshold. While `rd_ready_i` is low and no flush is pending, `rd_valid_o`, `rd_data_o` and `rd_last_o` hold.
- R7: A cycle with `flush_set_i`=1 sets `flush_o` on the next edge. Low `flush_set_i` never clears it. `flush_o` falls after exactly two cycles high, one cycle after all pointers and counters have reached zero.
- R8: While `flush_o` is high, `rd_valid_o` and `wr_ready_o` are low and writes are dropped. All stored bytes are discarded.
- R9: Bytes read before a flush are not replaced. The remainder of the cut frame never appears, and the next frame written after the flush comes out first and intact.
- R10: `wr_ready_o` is low while `DEPTH` bytes are stored and returns high after one byte is read. The store never overflows.
- R11: Bytes and last markers leave in exactly the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write byte present |
| wr_data_i | input | 8 | Write byte |
| wr_last_i | input | 1 | Write byte ends its frame |
| wr_ready_o | output | 1 | Byte is accepted this cycle |
| rd_valid_o | output | 1 | Read byte offered |
| rd_data_o | output | 8 | Read byte |
| rd_last_o | output | 1 | Read byte ends its frame |
| rd_ready_i | input | 1 | Transmitter takes the byte |
| thr_code_i | input | 3 | Release threshold code |
| store_fwd_i | input | 1 | Release complete frames only |
| flush_set_i | input | 1 | Pulse high to request a flush |
| flush_o | output | 1 | Flush in progress |

## Verification
The assertions watch several properties on every cycle. Stored byte and frame counts must stay within bounds. The flush must leave the counters at zero and may end only from the idle state. The read side must hold steady while back-pressured. Threshold release must never happen at a count equal to the threshold or in store-and-forward mode. Some behaviour can only be shown by the bench's scenarios. These are the exact threshold value for each code, the capture of the code at a frame's first byte, the two-cycle flush length, the loss of a truncated frame's remainder, and the ordering of frames under random traffic and random back-pressure.

// File: rtl/tx_tfifo_pkg.sv
package tx_tfifo_pkg;
  localparam int THR_W = 9;

  // upper half of the code space: 40 down to 16 in steps of 8
  function automatic logic [THR_W-1:0] thr_decode(input logic [2:0] code);
    logic [THR_W-1:0] lo;
    lo = THR_W'(code[1:0]);
    if (code[2]) thr_decode = (THR_W'(5) - lo) << 3;
    else         thr_decode = (lo + THR_W'(1)) << 6;
  endfunction
endpackage

// File: rtl/tx_tfifo_mem.sv
module tx_tfifo_mem #(
  parameter int DEPTH = 512,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_tfifo_ctrl.sv
module tx_tfifo_ctrl
  import tx_tfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_valid_i,
  input  logic          wr_last_i,
  output logic          wr_ready_o,
  output logic          wr_fire_o,
  input  logic          rd_ready_i,
  input  logic          rd_last_i,
  output logic          rd_valid_o,
  input  logic [2:0]    thr_code_i,
  input  logic          store_fwd_i,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] occ_o,
  output logic          idle_o
);
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    occ_q, eof_cnt_q;
  logic [THR_W-1:0] thr_q;
  logic             in_frame_q, busy_q;
  logic             full, thr_hit, rd_fire, eof_in, eof_out;

  assign full       = (occ_q == CW'(DEPTH));
  assign wr_ready_o = !clr_i && !full;
  assign wr_fire_o  = wr_valid_i && wr_ready_o;
  // head frame is incomplete only when no frame end is stored, so it is the tail frame
  assign thr_hit    = !store_fwd_i && (32'(occ_q) > 32'(thr_q));
  assign rd_valid_o = !clr_i && (occ_q != '0) && (busy_q || eof_cnt_q != '0 || thr_hit);
  assign rd_fire    = rd_valid_o && rd_ready_i;
  assign eof_in     = wr_fire_o && wr_last_i;
  assign eof_out    = rd_fire && rd_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      occ_q      <= '0;
      eof_cnt_q  <= '0;
      thr_q      <= thr_decode(3'd0);
      in_frame_q <= 1'b0;
      busy_q     <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      occ_q      <= '0;
      eof_cnt_q  <= '0;
      in_frame_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      if (wr_fire_o) begin
        wr_ptr_q   <= wr_ptr_q + 1'b1;
        in_frame_q <= !wr_last_i;
        if (!in_frame_q) thr_q <= thr_decode(thr_code_i);
      end
      if (rd_fire) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
        busy_q   <= !rd_last_i;
      end
      occ_q     <= occ_q + CW'(wr_fire_o) - CW'(rd_fire);
      eof_cnt_q <= eof_cnt_q + CW'(eof_in) - CW'(eof_out);
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign occ_o    = occ_q;
  assign idle_o   = (occ_q == '0) && (eof_cnt_q == '0) && (wr_ptr_q == '0) &&
                    (rd_ptr_q == '0) && !in_frame_q && !busy_q;

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CW'(DEPTH));
  assert_eof_bounded_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_cnt_q <= occ_q);
  assert_thr_strict_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!store_fwd_i && !busy_q && eof_cnt_q == '0 && 32'(occ_q) <= 32'(thr_q)) |-> !rd_valid_o);
  assert_sf_whole_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_fwd_i && !busy_q && eof_cnt_q == '0) |-> !rd_valid_o);
endmodule

// File: rtl/tx_tfifo_flush.sv
module tx_tfifo_flush (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_set_i,
  input  logic idle_i,
  output logic flush_o
);
  logic flush_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (flush_set_i) begin
      flush_q <= 1'b1;
      armed_q <= 1'b0;
    end else if (flush_q) begin
      // first cycle clears the control, second confirms idle
      if (armed_q && idle_i) begin
        flush_q <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        armed_q <= 1'b1;
      end
    end
  end

  assign flush_o = flush_q;

  assert_flush_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_set_i |=> flush_o);
  assert_flush_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !idle_i) |=> flush_o);
endmodule

// File: rtl/tx_thresh_fifo.sv
module tx_thresh_fifo #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int EW    = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  output logic              wr_ready_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  input  logic              rd_ready_i,
  input  logic [2:0]        thr_code_i,
  input  logic              store_fwd_i,
  input  logic              flush_set_i,
  output logic              flush_o
);
  logic          wr_fire, idle;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic [EW-1:0] rd_word;

  tx_tfifo_flush u_flush (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_set_i (flush_set_i),
    .idle_i      (idle),
    .flush_o     (flush_o)
  );

  tx_tfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (flush_o),
    .wr_valid_i  (wr_valid_i),
    .wr_last_i   (wr_last_i),
    .wr_ready_o  (wr_ready_o),
    .wr_fire_o   (wr_fire),
    .rd_ready_i  (rd_ready_i),
    .rd_last_i   (rd_word[DATA_W]),
    .rd_valid_o  (rd_valid_o),
    .thr_code_i  (thr_code_i),
    .store_fwd_i (store_fwd_i),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .occ_o       (occ),
    .idle_o      (idle)
  );

  tx_tfifo_mem #(.DEPTH(DEPTH), .W(EW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .waddr_i (wr_ptr),
    .wdata_i ({wr_last_i, wr_data_i}),
    .raddr_i (rd_ptr),
    .rdata_o (rd_word)
  );

  assign rd_data_o = rd_word[DATA_W-1:0];
  assign rd_last_o = rd_word[DATA_W];

  assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (occ == '0));
  assert_flush_ends_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_o) |-> $past(idle));
  assert_stream_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i && !flush_set_i && !flush_o && !store_fwd_i)
      |=> (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o)));
endmodule

// File: tb/tx_thresh_fifo_bench.sv
module tx_thresh_fifo_bench;
  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid = 1'b0, wr_last = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic       rd_valid, rd_last, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic [2:0] thr_code = '0;
  logic       store_fwd = 1'b0, flush_set = 1'b0, flush;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] q[$];

  always #2 clk = ~clk;

  tx_thresh_fifo #(.DEPTH(DEPTH)) u_tx_thresh_fifo (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_last_i(wr_last), .wr_ready_o(wr_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_last_o(rd_last), .rd_ready_i(rd_ready),
    .thr_code_i(thr_code), .store_fwd_i(store_fwd),
    .flush_set_i(flush_set), .flush_o(flush)
  );

  function automatic int thr_of(input int c);
    case (c)
      0: return 64;  1: return 128; 2: return 192; 3: return 256;
      4: return 40;  5: return 32;  6: return 24;  default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic l);
    wr_valid = 1'b1; wr_data = d; wr_last = l;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic push_n(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) push(8'(base + i), 1'b0);
  endtask

  task automatic pop(input logic [7:0] d, input logic l, input string req);
    rd_ready = 1'b1;
    chk(rd_valid === 1'b1, req, rd_valid, 1);
    chk(rd_data === d && rd_last === l, req, {rd_last, rd_data}, {l, d});
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic do_flush();
    flush_set = 1'b1;
    @(negedge clk);
    flush_set = 1'b0;
    chk(flush === 1'b1, "R7 set", flush, 1);
    chk(rd_valid === 1'b0 && wr_ready === 1'b0, "R8 gated", {rd_valid, wr_ready}, 0);
    @(negedge clk);
    chk(flush === 1'b1, "R7 second cycle", flush, 1);
    @(negedge clk);
    chk(flush === 1'b0, "R7 self clear", flush, 0);
    chk(rd_valid === 1'b0 && wr_ready === 1'b1, "R8 empty", {rd_valid, wr_ready}, 1);
  endtask

  task automatic run_random(input bit sf, input int ncyc);
    int left = 0, cyc = 0, eofs = 0;
    bit in_rd = 0;
    logic [8:0] e;
    store_fwd = sf;
    while ((cyc < ncyc || left != 0 || q.size() != 0) && cyc < ncyc + 20000) begin
      if (left == 0 && cyc < ncyc && $urandom % 4 == 0) begin
        left = 1 + $urandom % 80;
        thr_code = 3'($urandom);
      end
      wr_valid = (left != 0) && ($urandom % 4 != 0);
      wr_data  = 8'($urandom);
      wr_last  = (left == 1);
      rd_ready = ($urandom % 3 != 0);
      if (rd_valid && sf && !in_rd) chk(eofs > 0, "R4 random", eofs, 1);
      if (rd_valid && rd_ready) begin
        if (q.size() == 0) chk(1'b0, "R11 extra byte", rd_data, -1);
        else begin
          e = q.pop_front();
          chk({rd_last, rd_data} === e, "R11 order", {rd_last, rd_data}, e);
          in_rd = !rd_last;
          if (rd_last) eofs--;
        end
      end
      if (wr_valid && wr_ready) begin
        q.push_back({wr_last, wr_data});
        left--;
        if (wr_last) eofs++;
      end
      @(negedge clk);
      cyc++;
    end
    wr_valid = 1'b0; wr_last = 1'b0; rd_ready = 1'b0;
    chk(q.size() == 0, "R11 drained", q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rd_valid === 1'b0 && flush === 1'b0 && wr_ready === 1'b1, "reset",
        {rd_valid, flush, wr_ready}, 1);

    // R1 / R2: each code, boundary at threshold and threshold+1
    for (int c = 0; c < 8; c++) begin
      thr_code = 3'(c);
      push_n(thr_of(c), 8'h00);
      chk(rd_valid === 1'b0, "R2 at threshold", rd_valid, 0);
      push(8'hFF, 1'b0);
      chk(rd_valid === 1'b1, "R1 threshold+1", rd_valid, 1);
      do_flush();
    end

    // R5: code captured at first byte
    thr_code = 3'd7; push(8'h01, 1'b0);
    thr_code = 3'd0; push_n(16, 8'h02);
    chk(rd_valid === 1'b1, "R5 low code kept", rd_valid, 1);
    do_flush();
    thr_code = 3'd0; push(8'h01, 1'b0);
    thr_code = 3'd7; push_n(16, 8'h02);
    chk(rd_valid === 1'b0, "R5 high code kept", rd_valid, 0);
    do_flush();

    // R3: short complete frame
    thr_code = 3'd0;
    push_n(4, 8'h10);
    chk(rd_valid === 1'b0, "R3 before last", rd_valid, 0);
    push(8'h14, 1'b1);
    chk(rd_valid === 1'b1, "R3 after last", rd_valid, 1);
    for (int i = 0; i < 5; i++) pop(8'(8'h10 + i), i == 4, "R3 data");
    chk(rd_valid === 1'b0, "R3 empty", rd_valid, 0);

    // R4: store-and-forward holds past threshold
    store_fwd = 1'b1; thr_code = 3'd7;
    push_n(40, 8'h20);
    chk(rd_valid === 1'b0, "R4 held", rd_valid, 0);
    push(8'h48, 1'b1);
    chk(rd_valid === 1'b1, "R4 released", rd_valid, 1);
    for (int i = 0; i < 41; i++) pop(8'(8'h20 + i), i == 40, "R4 data");
    store_fwd = 1'b0;

    // R6: streaming continues below threshold; R9: flush truncates
    thr_code = 3'd7;
    push_n(20, 8'h60);
    for (int i = 0; i < 15; i++) pop(8'(8'h60 + i), 1'b0, "R6 data");
    chk(rd_valid === 1'b1, "R6 below threshold", rd_valid, 1);
    do_flush();
    chk(rd_valid === 1'b0, "R9 remainder gone", rd_valid, 0);
    push(8'hA0, 1'b0); push(8'hA1, 1'b0); push(8'hA2, 1'b1);
    pop(8'hA0, 1'b0, "R9 next frame");
    pop(8'hA1, 1'b0, "R9 next frame");
    pop(8'hA2, 1'b1, "R9 next frame");

    // R7: low request does not clear the flag
    push_n(3, 8'h30);
    flush_set = 1'b1; @(negedge clk); flush_set = 1'b0;
    chk(flush === 1'b1, "R7 not cleared by 0", flush, 1);
    repeat (2) @(negedge clk);
    chk(flush === 1'b0 && rd_valid === 1'b0, "R8 discarded", {flush, rd_valid}, 0);

    // R10: full
    thr_code = 3'd7;
    push_n(DEPTH, 8'h00);
    chk(wr_ready === 1'b0, "R10 full", wr_ready, 0);
    push(8'hEE, 1'b0);
    pop(8'h00, 1'b0, "R10 head");
    chk(wr_ready === 1'b1, "R10 space", wr_ready, 1);
    pop(8'h01, 1'b0, "R10 no overwrite");
    do_flush();

    // R11 random traffic, then store-and-forward
    run_random(1'b0, 4000);
    run_random(1'b1, 4000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule